// File: doc/BRIEF.md
# Bus-master DMA register window

This block decodes a 16-byte I/O window that gives two IDE channels an 8-byte register group each. Channel 0 answers at offsets 0 to 7 and channel 1 at offsets 8 to 15. In each group the four low bytes hold the control registers: command, mode, status and timing. The four high bytes hold the descriptor-table base address. The host side presents one access per cycle with an address, a size code and write data. Read data comes back one cycle later with a valid strobe.

The mode register is a single register shared by both windows. Its bits 4 and 5 block the interrupt of channel 0 and channel 1, and every write to it sends a one-cycle update pulse so that the interrupt logic can recompute its output. The status register mixes three kinds of bit: a live active flag from the DMA engine, error and interrupt flags that the engine sets and the host clears by writing 1, and two plain read/write bits.

Each channel has a small command state machine. Its states are CH_STOPPED, CH_STARTING and CH_RUNNING, and it has these transitions:
- CH_STOPPED to CH_STARTING on a command write with bit 0 set.
- CH_STARTING to CH_RUNNING on the next cycle, unless a command write clears bit 0, which sends it to CH_STOPPED.
- CH_RUNNING to CH_STOPPED on a command write with bit 0 clear.

While the machine is in CH_STARTING it drives the start request to the engine for exactly one cycle.

Top module: `dma_regwin`

## Requirements
- R1: A read accepted at a clock edge raises rd_valid for one cycle after that edge, with rd_data valid in that cycle. A write never raises rd_valid. Offset bit 3 selects the channel. Within a group, offset 0 is command, 1 is mode, 2 is status, 3 is timing and 4 to 7 are the table address.
- R2: The size codes are 0 for byte, 1 for 16-bit, 2 for 32-bit and 3 reserved. A control-register access that is not byte-sized reads as all ones: 0x0000FFFF for code 1, and 0xFFFFFFFF for codes 2 and 3. Such a write changes nothing.
- R3: Offset 1 reads the same shared mode byte through either window. A write stores only data bits 5:4, and every other mode bit reads 0. The mode_blk output shows the stored bits: bit 0 is mode bit 4 and bit 1 is mode bit 5.
- R4: mode_upd is high for exactly the one cycle after each byte write at offset 1 in either window, and is low otherwise.
- R5: Status bit 0 reads the channel's eng_active input as sampled at the read edge. Writes have no effect on it.
- R6: Status bit 1 (error) and bit 2 (interrupt) are set by one-cycle eng_err and eng_irq pulses. Writing 1 to a bit clears it and writing 0 keeps it. A pulse in the same cycle as a clearing write leaves the bit set.
- R7: Status bits 5 and 6 are plain read/write bits. Status bits 3, 4 and 7 read 0.
- R8: Offset 3 is an 8-bit read/write timing register, separate for each channel.
- R9: A command read returns bit 0 as 1 when the state machine is not in CH_STOPPED, and bit 3 as the last written direction. All other bits read 0. xfer_dir follows command bit 3.
- R10: A command write with bit 0 set while in CH_STOPPED drives start_pulse for that channel high for exactly the one cycle after the write edge. A repeated start while running gives no pulse. A write with bit 0 clear returns the machine to CH_STOPPED.
- R11: A 32-bit write at offset 4 loads the whole table address. A byte write at offset 4+k loads byte lane k. Bits 1:0 always read 0. A 32-bit read at offset 4 returns the whole value, and a byte read at offset 4+k returns lane k.
- R12: Any other access to offsets 4 to 7 (16-bit, 32-bit at offsets 5 to 7, or reserved size) reads as all ones of the access width and is ignored on write.
- R13: After reset all registers read 0, the state machines are in CH_STOPPED, and start_pulse, mode_blk and mode_upd are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_addr | input | ADDR_W | Byte offset in the window |
| acc_size | input | 2 | Size code (0 byte, 1 16-bit, 2 32-bit, 3 reserved) |
| acc_wdata | input | 32 | Write data, right-aligned |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data, right-aligned |
| eng_active | input | NUM_CH | Engine active flag per channel |
| eng_err | input | NUM_CH | Engine error pulse per channel |
| eng_irq | input | NUM_CH | Engine interrupt pulse per channel |
| start_pulse | output | NUM_CH | One-cycle start request per channel |
| xfer_dir | output | NUM_CH | Transfer direction per channel |
| mode_blk | output | NUM_CH | Interrupt block bits from the mode register |
| mode_upd | output | 1 | Mode register was written |

## Verification
The hardest case to reach is an engine error pulse that lands in the same cycle as a host write clearing that same status bit. Only this case shows which of the two wins. The bench reaches it by driving eng_err and the status write inside one shared negative-edge window, and then reads the status back. A second hard case is the single-cycle start window. The bench samples start_pulse at the first falling edge after the command write and again one cycle later. It also repeats the start write while the machine is running, to show that no second pulse appears.

// File: rtl/dmawin_pkg.sv
package dmawin_pkg;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        CH_STOPPED  = 2'd0,
        CH_STARTING = 2'd1,
        CH_RUNNING  = 2'd2
    } chan_state_e;

    localparam logic [1:0] OFF_CMD  = 2'd0;
    localparam logic [1:0] OFF_MODE = 2'd1;
    localparam logic [1:0] OFF_STAT = 2'd2;
    localparam logic [1:0] OFF_TIM  = 2'd3;

    function automatic logic [DATA_W-1:0] ones_of(input logic [1:0] sz);
        unique case (sz)
            SZ_BYTE: ones_of = DATA_W'(8'hFF);
            SZ_HALF: ones_of = DATA_W'(16'hFFFF);
            default: ones_of = '1;
        endcase
    endfunction
endpackage

// File: rtl/dmawin_decode.sv
module dmawin_decode
    import dmawin_pkg::*;
(
    input  logic [2:0]       off,
    input  logic [1:0]       size,
    output logic             hit_cmd,
    output logic             hit_mode,
    output logic             hit_stat,
    output logic             hit_tim,
    output logic             hit_tab_word,
    output logic [LANES-1:0] hit_tab_byte,
    output logic             miss
);
    logic is_byte;
    logic ctl;

    always_comb begin
        is_byte      = (size == SZ_BYTE);
        ctl          = !off[2];
        hit_cmd      = ctl && is_byte && (off[1:0] == OFF_CMD);
        hit_mode     = ctl && is_byte && (off[1:0] == OFF_MODE);
        hit_stat     = ctl && is_byte && (off[1:0] == OFF_STAT);
        hit_tim      = ctl && is_byte && (off[1:0] == OFF_TIM);
        hit_tab_word = (off == 3'd4) && (size == SZ_WORD);
        for (int k = 0; k < LANES; k++) begin
            hit_tab_byte[k] = off[2] && is_byte && (off[1:0] == 2'(k));
        end
        miss = !(hit_cmd || hit_mode || hit_stat || hit_tim ||
                 hit_tab_word || (|hit_tab_byte));
    end
endmodule

// File: rtl/dmawin_chan.sv
module dmawin_chan
    import dmawin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic              wr_stat,
    input  logic              wr_tim,
    input  logic              wr_tab_word,
    input  logic [LANES-1:0]  wr_tab_byte,
    input  logic [DATA_W-1:0] wdata,
    input  logic              eng_active,
    input  logic              eng_err,
    input  logic              eng_irq,
    output logic [7:0]        cmd_rd,
    output logic [7:0]        stat_rd,
    output logic [7:0]        tim_rd,
    output logic [DATA_W-1:0] tab_rd,
    output logic              start_pulse,
    output logic              xfer_dir
);
    chan_state_e       st_q, st_d;
    logic              dir_q, err_q, irq_q;
    logic [1:0]        plain_q;
    logic [7:0]        tim_q;
    logic [DATA_W-1:0] tab_q, tab_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_STOPPED;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_STOPPED:  if (wr_cmd && wdata[0]) st_d = CH_STARTING;
            CH_STARTING: st_d = (wr_cmd && !wdata[0]) ? CH_STOPPED : CH_RUNNING;
            CH_RUNNING:  if (wr_cmd && !wdata[0]) st_d = CH_STOPPED;
            default:     st_d = CH_STOPPED;
        endcase
    end

    // outputs
    always_comb begin
        start_pulse = (st_q == CH_STARTING);
        xfer_dir    = dir_q;
        cmd_rd      = {4'b0, dir_q, 2'b0, (st_q != CH_STOPPED)};
        stat_rd     = {1'b0, plain_q, 2'b0, irq_q, err_q, eng_active};
        tim_rd      = tim_q;
        tab_rd      = tab_q;
    end

    always_comb begin
        tab_d = tab_q;
        if (wr_tab_word) tab_d = wdata;
        for (int k = 0; k < LANES; k++) begin
            if (wr_tab_byte[k]) tab_d[8*k +: 8] = wdata[7:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= 1'b0;
            err_q   <= 1'b0;
            irq_q   <= 1'b0;
            plain_q <= 2'b0;
            tim_q   <= 8'h00;
            tab_q   <= '0;
        end else begin
            if (wr_cmd) dir_q <= wdata[3];
            err_q <= (err_q && !(wr_stat && wdata[1])) || eng_err;
            irq_q <= (irq_q && !(wr_stat && wdata[2])) || eng_irq;
            if (wr_stat) plain_q <= wdata[6:5];
            if (wr_tim)  tim_q   <= wdata[7:0];
            tab_q <= {tab_d[DATA_W-1:2], 2'b00};
        end
    end
endmodule

// File: rtl/dma_regwin.sv
module dma_regwin
    import dmawin_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = $clog2(NUM_CH) + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [31:0]       acc_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    input  logic [NUM_CH-1:0] eng_active,
    input  logic [NUM_CH-1:0] eng_err,
    input  logic [NUM_CH-1:0] eng_irq,
    output logic [NUM_CH-1:0] start_pulse,
    output logic [NUM_CH-1:0] xfer_dir,
    output logic [NUM_CH-1:0] mode_blk,
    output logic              mode_upd
);
    localparam int CH_W = ADDR_W - 3;

    logic [CH_W-1:0]   ch;
    logic [2:0]        off;
    logic              hit_cmd, hit_mode, hit_stat, hit_tim, hit_tab_word, miss;
    logic [LANES-1:0]  hit_tab_byte;
    logic              wr;
    logic [7:0]        cmd_rd  [NUM_CH];
    logic [7:0]        stat_rd [NUM_CH];
    logic [7:0]        tim_rd  [NUM_CH];
    logic [31:0]       tab_rd  [NUM_CH];
    logic [NUM_CH-1:0] mode_q;
    logic              mode_upd_q, rd_valid_q;
    logic [31:0]       rd_d, rd_q;

    assign ch  = acc_addr[ADDR_W-1:3];
    assign off = acc_addr[2:0];
    assign wr  = acc_valid && acc_write;

    dmawin_decode u_dec (
        .off(off), .size(acc_size),
        .hit_cmd(hit_cmd), .hit_mode(hit_mode), .hit_stat(hit_stat),
        .hit_tim(hit_tim), .hit_tab_word(hit_tab_word),
        .hit_tab_byte(hit_tab_byte), .miss(miss)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic sel;
        assign sel = wr && (ch == CH_W'(g));
        dmawin_chan u_chan (
            .clk(clk), .rst_n(rst_n),
            .wr_cmd(sel && hit_cmd), .wr_stat(sel && hit_stat),
            .wr_tim(sel && hit_tim), .wr_tab_word(sel && hit_tab_word),
            .wr_tab_byte({LANES{sel}} & hit_tab_byte),
            .wdata(acc_wdata),
            .eng_active(eng_active[g]), .eng_err(eng_err[g]), .eng_irq(eng_irq[g]),
            .cmd_rd(cmd_rd[g]), .stat_rd(stat_rd[g]), .tim_rd(tim_rd[g]),
            .tab_rd(tab_rd[g]),
            .start_pulse(start_pulse[g]), .xfer_dir(xfer_dir[g])
        );
    end

    always_comb begin
        rd_d = ones_of(acc_size);
        if (!miss) begin
            rd_d = 32'h0;
            if (hit_cmd)      rd_d[7:0] = cmd_rd[ch];
            if (hit_mode)     rd_d[7:0] = 8'({mode_q, 4'b0000});
            if (hit_stat)     rd_d[7:0] = stat_rd[ch];
            if (hit_tim)      rd_d[7:0] = tim_rd[ch];
            if (hit_tab_word) rd_d      = tab_rd[ch];
            if (|hit_tab_byte) rd_d[7:0] = tab_rd[ch][{off[1:0], 3'b000} +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= '0;
            mode_upd_q <= 1'b0;
            rd_valid_q <= 1'b0;
            rd_q       <= 32'h0;
        end else begin
            mode_upd_q <= wr && hit_mode;
            if (wr && hit_mode) mode_q <= acc_wdata[4 +: NUM_CH];
            rd_valid_q <= acc_valid && !acc_write;
            if (acc_valid && !acc_write) rd_q <= rd_d;
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_q;
    assign mode_blk = mode_q;
    assign mode_upd = mode_upd_q;
endmodule

// File: rtl/dma_regwin_chk.sv
module dma_regwin_chk
    import dmawin_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = $clog2(NUM_CH) + 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [1:0]        acc_size,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic [NUM_CH-1:0] eng_active,
    input logic [NUM_CH-1:0] start_pulse,
    input logic [NUM_CH-1:0] mode_blk,
    input logic              mode_upd
);
    logic mode_wr;
    assign mode_wr = acc_valid && acc_write && (acc_addr[2:0] == 3'd1) && (acc_size == SZ_BYTE);

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> rd_valid);  // R1
    AST_NO_RD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid || acc_write) |=> !rd_valid);  // R1
    AST_WIDE_CTRL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && !acc_addr[2] && acc_size == SZ_WORD) |=> (rd_data == 32'hFFFF_FFFF));  // R2
    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> $stable(mode_blk));  // R3
    AST_MODE_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> mode_upd);  // R4
    AST_MODE_UPD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> !mode_upd);  // R4
    AST_ACTIVE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_addr == ADDR_W'(2) && acc_size == SZ_BYTE)
        |=> (rd_data[0] == $past(eng_active[0])));  // R5
    AST_TAB_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_addr[2:0] == 3'd4 && acc_size == SZ_WORD)
        |=> (rd_data[1:0] == 2'b00));  // R11

    for (genvar g = 0; g < NUM_CH; g++) begin : g_pulse
        AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            start_pulse[g] |=> !start_pulse[g]);  // R10
    end
endmodule

bind dma_regwin dma_regwin_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dma_regwin_bench.sv
module dma_regwin_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [3:0]  acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [1:0]  eng_active = '0;
    logic [1:0]  eng_err = '0;
    logic [1:0]  eng_irq = '0;
    logic [1:0]  start_pulse, xfer_dir, mode_blk;
    logic        mode_upd;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dma_regwin u_dma_regwin (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_size = s; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_size = s;
        @(negedge clk);
        chk("R1 rd_valid", 32'(rd_valid), 32'd1);
        d = rd_data;
        acc_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R13 start_pulse", 32'(start_pulse), 0);
        chk("R13 mode_blk", 32'(mode_blk), 0);
        chk("R13 mode_upd", 32'(mode_upd), 0);
        rd(4'd0, 2'd0, d); chk("R13 cmd", d, 0);
        rd(4'd1, 2'd0, d); chk("R13 mode", d, 0);
        rd(4'd2, 2'd0, d); chk("R13 status", d, 0);
        rd(4'd11, 2'd0, d); chk("R13 timing", d, 0);
        rd(4'd4, 2'd2, d); chk("R13 table", d, 0);
    endtask

    task automatic t_timing();
        logic [31:0] d;
        wr(4'd3, 2'd0, 32'hA5);
        wr(4'd11, 2'd0, 32'h3C);
        rd(4'd3, 2'd0, d);  chk("R8 ch0 timing", d, 32'hA5);
        rd(4'd11, 2'd0, d); chk("R8 ch1 timing", d, 32'h3C);
        @(negedge clk);
        chk("R1 no rd_valid idle", 32'(rd_valid), 0);
    endtask

    task automatic t_mode();
        logic [31:0] d;
        wr(4'd9, 2'd0, 32'hFF);
        chk("R4 mode_upd pulse", 32'(mode_upd), 1);
        chk("R3 mode_blk", 32'(mode_blk), 2'b11);
        @(negedge clk);
        chk("R4 mode_upd drops", 32'(mode_upd), 0);
        rd(4'd1, 2'd0, d); chk("R3 mode via ch0", d, 32'h30);
        wr(4'd1, 2'd0, 32'h10);
        rd(4'd9, 2'd0, d); chk("R3 mode via ch1", d, 32'h10);
        chk("R3 mode_blk single", 32'(mode_blk), 2'b01);
    endtask

    task automatic t_wide();
        logic [31:0] d;
        wr(4'd3, 2'd1, 32'hFFFF);
        rd(4'd3, 2'd0, d); chk("R2 half write ignored", d, 32'hA5);
        rd(4'd0, 2'd2, d); chk("R2 word read ones", d, 32'hFFFF_FFFF);
        rd(4'd2, 2'd1, d); chk("R2 half read ones", d, 32'h0000_FFFF);
        rd(4'd3, 2'd3, d); chk("R2 reserved read ones", d, 32'hFFFF_FFFF);
        wr(4'd1, 2'd2, 32'h30);
        chk("R2 wide mode write no upd", 32'(mode_upd), 0);
        rd(4'd1, 2'd0, d); chk("R2 mode unchanged", d, 32'h10);
    endtask

    task automatic t_status();
        logic [31:0] d;
        @(negedge clk); eng_active = 2'b10;
        rd(4'd10, 2'd0, d); chk("R5 active read", d, 32'h01);
        wr(4'd10, 2'd0, 32'h00);
        rd(4'd10, 2'd0, d); chk("R5 active not writable", d, 32'h01);
        @(negedge clk); eng_active = 2'b00;
        rd(4'd10, 2'd0, d); chk("R5 active follows", d, 32'h00);
        wr(4'd2, 2'd0, 32'h7F);
        rd(4'd2, 2'd0, d); chk("R7 plain bits", d, 32'h60);
        @(negedge clk); eng_err = 2'b01; eng_irq = 2'b01;
        @(negedge clk); eng_err = 2'b00; eng_irq = 2'b00;
        rd(4'd2, 2'd0, d); chk("R6 flags set", d, 32'h66);
        rd(4'd10, 2'd0, d); chk("R6 other channel clear", d, 32'h00);
        wr(4'd2, 2'd0, 32'h62);
        rd(4'd2, 2'd0, d); chk("R6 w1c error", d, 32'h64);
        wr(4'd2, 2'd0, 32'h64);
        rd(4'd2, 2'd0, d); chk("R6 w1c irq", d, 32'h60);
        @(negedge clk);
        eng_err = 2'b01;
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 4'd2; acc_size = 2'd0; acc_wdata = 32'h62;
        @(negedge clk);
        eng_err = 2'b00; acc_valid = 1'b0; acc_write = 1'b0;
        rd(4'd2, 2'd0, d); chk("R6 set wins over clear", d, 32'h62);
        wr(4'd2, 2'd0, 32'h06);
        rd(4'd2, 2'd0, d); chk("R7 plain cleared", d, 32'h00);
    endtask

    task automatic t_cmd();
        logic [31:0] d;
        wr(4'd8, 2'd0, 32'h09);
        chk("R10 start pulse", 32'(start_pulse), 2'b10);
        chk("R9 dir", 32'(xfer_dir), 2'b10);
        @(negedge clk);
        chk("R10 pulse one cycle", 32'(start_pulse), 0);
        wr(4'd8, 2'd0, 32'h09);
        chk("R10 no pulse while running", 32'(start_pulse), 0);
        rd(4'd8, 2'd0, d); chk("R9 cmd read", d, 32'h09);
        wr(4'd8, 2'd0, 32'hFF);
        chk("R10 no pulse on 0xFF", 32'(start_pulse), 0);
        rd(4'd8, 2'd0, d); chk("R9 cmd mask", d, 32'h09);
        wr(4'd8, 2'd0, 32'h00);
        rd(4'd8, 2'd0, d); chk("R10 stopped", d, 32'h00);
        chk("R9 dir cleared", 32'(xfer_dir), 0);
        wr(4'd8, 2'd0, 32'h01);
        chk("R10 restart pulse", 32'(start_pulse), 2'b10);
    endtask

    task automatic t_table();
        logic [31:0] d;
        wr(4'd4, 2'd2, 32'h1234_5677);
        rd(4'd4, 2'd2, d); chk("R11 word load", d, 32'h1234_5674);
        wr(4'd6, 2'd0, 32'hAB);
        rd(4'd4, 2'd2, d); chk("R11 lane 2", d, 32'h12AB_5674);
        rd(4'd7, 2'd0, d); chk("R11 byte read", d, 32'h12);
        wr(4'd4, 2'd0, 32'hFF);
        rd(4'd4, 2'd2, d); chk("R11 low bits zero", d, 32'h12AB_56FC);
        wr(4'd4, 2'd1, 32'h0);
        rd(4'd4, 2'd2, d); chk("R12 half write ignored", d, 32'h12AB_56FC);
        rd(4'd4, 2'd1, d); chk("R12 half read ones", d, 32'h0000_FFFF);
        rd(4'd5, 2'd2, d); chk("R12 misaligned ones", d, 32'hFFFF_FFFF);
        rd(4'd4, 2'd3, d); chk("R12 reserved ones", d, 32'hFFFF_FFFF);
        rd(4'd12, 2'd2, d); chk("R11 ch1 table separate", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timing();
        t_mode();
        t_wide();
        t_status();
        t_cmd();
        t_table();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule